// File: doc/BRIEF.md
# Masked-Write GPIO with Shared Interrupt Line

This block gives a processor sixteen general-purpose pins behind a small word-addressed register bus. Software picks each pin's direction, drives output levels, reads back the live pin levels and chooses which of the upper eight pins may raise one shared, active-high interrupt request. Writes to the output register carry a per-pin write mask in their upper half-word. A single pin can therefore be set or cleared in one bus write, with no read-modify-write sequence that another agent could interleave.

A two-bit control register gates the block. One bit enables sampling and register updates. The other bit holds the pin registers in a cleared state. The usual bring-up writes both bits set, then the enable bit alone. The low-power state keeps the clear bit set and the enable bit clear, and that is also the value the control register takes after the hardware reset. Pin inputs pass through a two-flop synchronizer before they are sampled.

Word address map: 0 direction, 1 output, 2 pin state (read only), 3 interrupt enable, 4 control. Reads are combinational on `addr_i`. Writes take effect at the clock edge on which `wr_en_i` is high.

Top module: `gpio_shared_irq`

## Requirements
- R1: After `rst_ni` is released, the direction, output and interrupt-enable registers read 0, the control register reads 2 (clear bit set, enable bit clear), `pin_oe_o`, `pin_o` and `irq_o` are all 0.
- R2: The direction register at address 0 is read/write in bits 15:0. Bit n set drives `pin_oe_o[n]` high (pin n is an output). Bits 31:16 read 0.
- R3: A write to address 1 loads output bit n from data bit n only when data bit 16+n is 1. Other bits keep their value. The register reads back in bits 15:0, bits 31:16 read 0, and it drives `pin_o`.
- R4: Address 2 returns the pin levels in bits 15:0. A change on `pin_i` becomes visible on the third rising clock edge after it is applied, and not on the second.
- R5: Interrupt-enable bit k (k = 0..7, at address 3) gates pin 8+k. `irq_o` is the OR over those pins of the sampled level ANDed with the enable bit. Bits 31:8 of address 3 read 0.
- R6: Pins 0 to 7 never affect `irq_o`.
- R7: While control bit 1 (clear) is set, the direction, output and interrupt-enable registers are held at 0 from the next edge on, and bus writes to them are ignored.
- R8: While control bit 0 (enable) is 0, the pin-state register holds its last sampled value, and writes to the direction, output and interrupt-enable registers are ignored.
- R9: The control register at address 4 is always writable and reads back bits 1:0. Writing 3 and then 1 brings the block up into normal operation.
- R10: Addresses 5 to 7 read 0. Writes to address 2 and to addresses 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pin_i | input | 16 | Pin input levels (asynchronous) |
| pin_o | output | 16 | Pin output levels |
| pin_oe_o | output | 16 | Pin output enables (1 = output) |
| irq_o | output | 1 | Shared interrupt request for pins 8 to 15 |

## Verification
Register writes are due on the rising edge that ends the write cycle. The read-back, `pin_o`, `pin_oe_o` and a changed `irq_o` are therefore checked at the following falling edge. A pin change is applied at a falling edge and checked at the falling edges after the second and third rising edges, so the bench pins down the exact synchronizer latency. The effect of the clear bit lands one edge after the control write, and all checks of it are made after that edge. The bench sweeps all 256 enable codes against sixteen pin patterns and computes each expected request arithmetically.

// File: rtl/gpio_shared_irq_pkg.sv
package gpio_shared_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_OUT  = 3'd1,
    REG_PIN  = 3'd2,
    REG_IEN  = 3'd3,
    REG_CTRL = 3'd4
  } reg_addr_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_CLR_BIT = 1;
  localparam logic [1:0]  CTRL_RST_VAL = 2'b10;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q[b] <= 1'b0;
      else if (clr_i)             q[b] <= 1'b0;
      else if (we_i && mask_i[b]) q[b] <= val_i[b];
    end
  end

  assign q_o = q;
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             irq_o
);
  logic [WIDTH-1:0] gated;

  for (genvar k = 0; k < WIDTH; k++) begin : g_gate
    assign gated[k] = lvl_i[k] & en_i[k];
  end

  assign irq_o = |gated;
endmodule

// File: rtl/gpio_shared_irq.sv
module gpio_shared_irq
  import gpio_shared_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 16,
  parameter int unsigned SHARED_LO = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*NUM_PINS-1:0] wdata_i,
  output logic [2*NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic [NUM_PINS-1:0]   pin_o,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic                  irq_o
);
  localparam int unsigned DW = 2 * NUM_PINS;
  localparam int unsigned IW = NUM_PINS - SHARED_LO;

  logic [1:0]          ctrl_q;
  logic [NUM_PINS-1:0] pin_sync, pin_state, dir_q, out_q;
  logic [IW-1:0]       ien_q;
  logic                en, clr, wr_ok;
  logic                we_dir, we_out, we_ien;

  assign en    = ctrl_q[CTRL_EN_BIT];
  assign clr   = ctrl_q[CTRL_CLR_BIT];
  assign wr_ok = wr_en_i & en & ~clr;

  assign we_dir = wr_ok && (addr_i == REG_DIR);
  assign we_out = wr_ok && (addr_i == REG_OUT);
  assign we_ien = wr_ok && (addr_i == REG_IEN);

  // control is reachable in every state so the block can be woken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ctrl_q <= CTRL_RST_VAL;
    else if (wr_en_i && addr_i == REG_CTRL)   ctrl_q <= wdata_i[1:0];
  end

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pin_state <= '0;
    else if (en)  pin_state <= pin_sync;
  end

  gpio_mask_reg #(.WIDTH(NUM_PINS)) u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .we_i   (we_dir),
    .mask_i ({NUM_PINS{1'b1}}),
    .val_i  (wdata_i[NUM_PINS-1:0]),
    .q_o    (dir_q)
  );

  gpio_mask_reg #(.WIDTH(NUM_PINS)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .we_i   (we_out),
    .mask_i (wdata_i[DW-1:NUM_PINS]),
    .val_i  (wdata_i[NUM_PINS-1:0]),
    .q_o    (out_q)
  );

  gpio_mask_reg #(.WIDTH(IW)) u_ien (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .we_i   (we_ien),
    .mask_i ({IW{1'b1}}),
    .val_i  (wdata_i[IW-1:0]),
    .q_o    (ien_q)
  );

  gpio_irq_merge #(.WIDTH(IW)) u_irq (
    .lvl_i (pin_state[NUM_PINS-1:SHARED_LO]),
    .en_i  (ien_q),
    .irq_o (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_DIR:  rdata_o[NUM_PINS-1:0] = dir_q;
      REG_OUT:  rdata_o[NUM_PINS-1:0] = out_q;
      REG_PIN:  rdata_o[NUM_PINS-1:0] = pin_state;
      REG_IEN:  rdata_o[IW-1:0]       = ien_q;
      REG_CTRL: rdata_o[1:0]          = ctrl_q;
      default:  rdata_o = '0;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
endmodule

// File: rtl/gpio_shared_irq_chk.sv
module gpio_shared_irq_chk
  import gpio_shared_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 16,
  parameter int unsigned SHARED_LO = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           wr_en_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [2*NUM_PINS-1:0]          wdata_i,
  input logic [NUM_PINS-1:0]            pin_o,
  input logic [NUM_PINS-1:0]            pin_oe_o,
  input logic                           irq_o,
  input logic [1:0]                     ctrl_q,
  input logic [NUM_PINS-1:0]            pin_state,
  input logic [NUM_PINS-SHARED_LO-1:0]  ien_q
);
  localparam int unsigned DW = 2 * NUM_PINS;

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DIR && ctrl_q == 2'b01)
      |=> pin_oe_o == $past(wdata_i[NUM_PINS-1:0]));

  p_masked_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_OUT && ctrl_q == 2'b01)
      |=> ((pin_o ^ $past(pin_o)) & ~$past(wdata_i[DW-1:NUM_PINS])) == '0);

  p_irq_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);

  p_clear_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTRL_CLR_BIT] |=> (pin_oe_o == '0 && pin_o == '0 && !irq_o));

  p_sample_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[CTRL_EN_BIT] |=> $stable(pin_state));

  p_ctrl_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_CTRL) |=> ctrl_q == $past(wdata_i[1:0]));
endmodule

bind gpio_shared_irq gpio_shared_irq_chk #(
  .NUM_PINS  (NUM_PINS),
  .SHARED_LO (SHARED_LO)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .irq_o     (irq_o),
  .ctrl_q    (ctrl_q),
  .pin_state (pin_state),
  .ien_q     (ien_q)
);

// File: tb/gpio_shared_irq_tb.sv
`timescale 1ns/1ps
module gpio_shared_irq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] pin_i = '0;
  logic [15:0] pin_o, pin_oe_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_shared_irq u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .pin_i    (pin_i),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o),
    .irq_o    (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] out_m, dir_m, pins, held;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 dir", v, 0);
    rd(3'd1, v); chk("R1 out", v, 0);
    rd(3'd3, v); chk("R1 ien", v, 0);
    rd(3'd4, v); chk("R1 ctrl", v, 2);
    chk("R1 oe", {16'h0, pin_oe_o}, 0);
    chk("R1 pin_o", {16'h0, pin_o}, 0);
    chk("R1 irq", {31'h0, irq_o}, 0);

    // R7 writes ignored in the low-power clear state
    wr(3'd0, 32'h0000_FFFF);
    rd(3'd0, v); chk("R7 dir write while clear", v, 0);
    wr(3'd4, 32'd3);
    wr(3'd0, 32'h0000_A5A5);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R7 dir ignored", v, 0);
    rd(3'd1, v); chk("R7 out ignored", v, 0);
    // R9 bring-up
    rd(3'd4, v); chk("R9 ctrl=3", v, 3);
    wr(3'd4, 32'd1);
    rd(3'd4, v); chk("R9 ctrl=1", v, 1);

    // R2 direction sweep
    for (int k = 0; k < 20; k++) begin
      dir_m = 16'(k * 16'h3B91 + 16'h0F1);
      wr(3'd0, {16'hFFFF, dir_m});
      rd(3'd0, v); chk("R2 dir readback", v, {16'h0, dir_m});
      chk("R2 pin_oe_o", {16'h0, pin_oe_o}, {16'h0, dir_m});
    end

    // R3 masked output writes
    out_m = '0;
    for (int i = 0; i < 16; i++) begin
      wr(3'd1, {16'(1 << i), 16'hFFFF});
      out_m = out_m | 16'(1 << i);
      rd(3'd1, v); chk("R3 single set", v, {16'h0, out_m});
    end
    for (int k = 0; k < 64; k++) begin
      logic [15:0] m, d;
      m = 16'(k * 16'h9E37 + 16'h1234);
      d = 16'(k * 16'h5A3 + 16'h0C1);
      wr(3'd1, {m, d});
      out_m = (out_m & ~m) | (d & m);
      rd(3'd1, v); chk("R3 masked readback", v, {16'h0, out_m});
      chk("R3 pin_o", {16'h0, pin_o}, {16'h0, out_m});
    end

    // R4 input latency
    addr_i = 3'd2;
    for (int k = 0; k < 6; k++) begin
      logic [15:0] prev;
      prev = pins;
      if (k == 0) prev = '0;
      pins = 16'(k * 16'h6D2B + 16'h8001);
      @(negedge clk); pin_i = pins;
      @(negedge clk);
      @(negedge clk); rd(3'd2, v); chk("R4 not yet after 2 edges", v, {16'h0, prev});
      @(negedge clk); rd(3'd2, v); chk("R4 visible after 3 edges", v, {16'h0, pins});
    end

    // R5 / R6 interrupt sweep
    for (int p = 0; p < 16; p++) begin
      pins = (p < 4) ? 16'(p * 16'h0055) : 16'(p * 16'h1D3B);
      @(negedge clk); pin_i = pins;
      repeat (3) @(negedge clk);
      for (int e = 0; e < 256; e++) begin
        wr(3'd3, 32'hFFFF_FF00 | 32'(e));
        chk((p < 4) ? "R6 low pins no irq" : "R5 irq",
            {31'h0, irq_o}, {31'h0, |(pins[15:8] & 8'(e))});
      end
      rd(3'd3, v); chk("R5 ien upper zero", v, 32'h0000_00FF);
    end

    // R10 unmapped and read-only addresses
    rd(3'd5, v); chk("R10 addr5", v, 0);
    rd(3'd6, v); chk("R10 addr6", v, 0);
    rd(3'd7, v); chk("R10 addr7", v, 0);
    wr(3'd2, 32'h0000_0000);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R10 pin state unchanged", v, {16'h0, pins});
    rd(3'd0, v); chk("R10 dir unchanged", v, {16'h0, dir_m});
    rd(3'd1, v); chk("R10 out unchanged", v, {16'h0, out_m});
    rd(3'd4, v); chk("R10 ctrl unchanged", v, 1);

    // R8 sampling held with enable off
    held = pins;
    wr(3'd4, 32'd0);
    @(negedge clk); pin_i = ~pins;
    repeat (5) @(negedge clk);
    rd(3'd2, v); chk("R8 pin state held", v, {16'h0, held});
    chk("R8 irq held", {31'h0, irq_o}, {31'h0, |held[15:8]});
    wr(3'd0, 32'h0000_0000);
    wr(3'd1, 32'hFFFF_0000);
    wr(3'd3, 32'h0);
    rd(3'd0, v); chk("R8 dir ignored", v, {16'h0, dir_m});
    rd(3'd1, v); chk("R8 out ignored", v, {16'h0, out_m});
    rd(3'd3, v); chk("R8 ien ignored", v, 32'hFF);
    wr(3'd4, 32'd1);
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R8 resumes sampling", v, {16'h0, ~held});

    // R7 clear after operation
    wr(3'd4, 32'd3);
    @(negedge clk);
    rd(3'd0, v); chk("R7 dir cleared", v, 0);
    rd(3'd1, v); chk("R7 out cleared", v, 0);
    rd(3'd3, v); chk("R7 ien cleared", v, 0);
    chk("R7 oe cleared", {16'h0, pin_oe_o}, 0);
    chk("R7 irq low", {31'h0, irq_o}, 0);
    wr(3'd3, 32'hFF);
    rd(3'd3, v); chk("R7 ien write ignored", v, 0);
    wr(3'd4, 32'd1);
    wr(3'd3, 32'hFF);
    rd(3'd3, v); chk("R9 ien writable after bring-up", v, 32'hFF);

    done = 1;
    summary();
    $finish;
  end
endmodule